// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a pipelined integer datapath for multi-word modular arithmetic, where large numbers are held as 52-bit limbs inside 64-bit containers. The input vector is split into independent 64-bit lanes. Each lane takes an accumulator word and two multiplicand words. Only the low 52 bits of each multiplicand are multiplied, which gives a 104-bit unsigned product. A single select bit chooses which 52-bit half of that product is added to the 64-bit accumulator: the upper half or the lower half.

Software chains the two modes to build full limb products. For each pair of limbs it issues one operation in low mode and one in high mode, and it carries the overflow between limbs. The number of active lanes is set by a parameter: two lanes give a 128-bit vector and four lanes give a 256-bit vector. The port width is fixed to the largest form. Any lane beyond the configured count reads nothing and drives zero. The unit can accept one operation on every clock, and each result comes out a fixed number of cycles later.

Top module: `pmac52_unit`

## Requirements
- R1: Bits 63:52 of each multiplicand lane have no effect on the result. Only bits 51:0 enter the multiplier.
- R2: The two 52-bit fields are multiplied as unsigned numbers into a full 104-bit product. If either field is zero, the lane result equals the accumulator.
- R3: When `in_hi_sel` is 1, the lane result is the accumulator plus product bits 103:52, zero-extended to 64 bits.
- R4: When `in_hi_sel` is 0, the lane result is the accumulator plus product bits 51:0, zero-extended to 64 bits.
- R5: The 64-bit addition wraps modulo 2^64. The carry out of bit 63 is dropped.
- R6: `out_valid` and the matching `out_sum` appear exactly three rising edges after the edge that samples `in_valid`=1. One new operation is accepted on every edge.
- R7: Lane j uses bits 64*j+63 down to 64*j of every vector port, and lanes do not affect one another. Port lanes at index `LANES` and above are ignored on input and read as zero on output.
- R8: A synchronous active-high `rst` clears every pipeline valid bit. This includes operations still in flight.
- R9: The select bit is sampled together with its operands. Back-to-back operations with different select values each produce a result in their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the inputs are valid this cycle |
| in_hi_sel | input | 1 | 1 adds the upper product half, 0 adds the lower half |
| in_acc | input | 256 | Packed 64-bit accumulator words |
| in_mula | input | 256 | Packed first multiplicands (bits 51:0 of each lane used) |
| in_mulb | input | 256 | Packed second multiplicands (bits 51:0 of each lane used) |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | 256 | Packed 64-bit results, with inactive lanes zero |

## Verification
The main function is driven with all-ones 52-bit fields in both modes. This tells the upper half apart from the lower half, because the two halves give very different values (2^52-2 and 1). Multiplicands carrying junk in bits 63:52 show whether the field is masked before the multiply. An accumulator of all ones with a nonzero addend exposes a missing wrap. Zero multiplicands isolate the accumulator path, and a product of exactly 2^53 checks where the halves split. Rotated operands in the second lane, junk in the unused port lanes, and alternating modes on consecutive cycles separate lane leakage and mode capture from the arithmetic.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  localparam int LANE_W  = 64;
  localparam int FIELD_W = 52;
  localparam int PROD_W  = 2 * FIELD_W;

  typedef logic [LANE_W-1:0]  lane_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [PROD_W-1:0]  prod_t;

  // Full unsigned product of two 52-bit fields.
  function automatic prod_t field_mul(input field_t a, input field_t b);
    return prod_t'(a) * prod_t'(b);
  endfunction

  // Zero-extended upper or lower half of a product.
  function automatic lane_t pick_half(input prod_t p, input logic hi);
    lane_t r;
    if (hi) r = lane_t'(p[PROD_W-1:FIELD_W]);
    else    r = lane_t'(p[FIELD_W-1:0]);
    return r;
  endfunction

  // Modulo 2^64 accumulation.
  function automatic lane_t wrap_add(input lane_t acc, input lane_t addend);
    return acc + addend;
  endfunction
endpackage

// File: rtl/pmac_capture.sv
module pmac_capture
  import pmac_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic                           in_hi_sel,
  input  logic [LANES-1:0][LANE_W-1:0]   in_acc,
  input  logic [LANES-1:0][LANE_W-1:0]   in_mula,
  input  logic [LANES-1:0][LANE_W-1:0]   in_mulb,
  output logic                           s1_valid,
  output logic                           s1_hi,
  output logic [LANES-1:0][LANE_W-1:0]   s1_acc,
  output logic [LANES-1:0][FIELD_W-1:0]  s1_a,
  output logic [LANES-1:0][FIELD_W-1:0]  s1_b
);
  localparam int TOP_W = LANE_W - FIELD_W;

  logic [LANES-1:0][TOP_W-1:0] unused_field_tops;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) s1_hi <= in_hi_sel;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign unused_field_tops[g] = in_mula[g][LANE_W-1:FIELD_W] ^ in_mulb[g][LANE_W-1:FIELD_W];
    always_ff @(posedge clk) begin
      if (in_valid) begin
        s1_acc[g] <= in_acc[g];
        s1_a[g]   <= in_mula[g][FIELD_W-1:0];
        s1_b[g]   <= in_mulb[g][FIELD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pmac_mul_stage.sv
module pmac_mul_stage
  import pmac_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           s1_valid,
  input  logic                           s1_hi,
  input  logic [LANES-1:0][LANE_W-1:0]   s1_acc,
  input  logic [LANES-1:0][FIELD_W-1:0]  s1_a,
  input  logic [LANES-1:0][FIELD_W-1:0]  s1_b,
  output logic                           s2_valid,
  output logic                           s2_hi,
  output logic [LANES-1:0][LANE_W-1:0]   s2_acc,
  output logic [LANES-1:0][PROD_W-1:0]   s2_prod
);
  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) s2_hi <= s1_hi;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (s1_valid) begin
        s2_acc[g]  <= s1_acc[g];
        s2_prod[g] <= field_mul(s1_a[g], s1_b[g]);
      end
    end
  end
endmodule

// File: rtl/pmac_sum_stage.sv
module pmac_sum_stage
  import pmac_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           s2_valid,
  input  logic                           s2_hi,
  input  logic [LANES-1:0][LANE_W-1:0]   s2_acc,
  input  logic [LANES-1:0][PROD_W-1:0]   s2_prod,
  output logic                           s3_valid,
  output logic [LANES-1:0][LANE_W-1:0]   s3_sum
);
  always_ff @(posedge clk) begin
    if (rst) s3_valid <= 1'b0;
    else     s3_valid <= s2_valid;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_t addend;
    assign addend = pick_half(s2_prod[g], s2_hi);
    always_ff @(posedge clk) begin
      if (s2_valid) s3_sum[g] <= wrap_add(s2_acc[g], addend);
    end
  end
endmodule

// File: rtl/pmac52_unit.sv
module pmac52_unit
  import pmac_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int PORT_LANES = 4,
  localparam int VEC_W     = PORT_LANES * 64,
  localparam int USED_W    = LANES * 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_hi_sel,
  input  logic [VEC_W-1:0] in_acc,
  input  logic [VEC_W-1:0] in_mula,
  input  logic [VEC_W-1:0] in_mulb,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_sum
);
  logic                           s1_valid, s1_hi;
  logic [LANES-1:0][LANE_W-1:0]   s1_acc;
  logic [LANES-1:0][FIELD_W-1:0]  s1_a, s1_b;
  logic                           s2_valid, s2_hi;
  logic [LANES-1:0][LANE_W-1:0]   s2_acc;
  logic [LANES-1:0][PROD_W-1:0]   s2_prod;
  logic                           s3_valid;
  logic [LANES-1:0][LANE_W-1:0]   s3_sum;

  // Named lane-0 taps for the checker.
  logic [PROD_W-1:0] mon_prod0;
  logic [LANE_W-1:0] mon_acc0;
  logic [LANE_W-1:0] mon_sum0;
  assign mon_prod0 = s2_prod[0];
  assign mon_acc0  = s2_acc[0];
  assign mon_sum0  = s3_sum[0];

  pmac_capture #(.LANES(LANES)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi_sel(in_hi_sel),
    .in_acc(in_acc[USED_W-1:0]), .in_mula(in_mula[USED_W-1:0]),
    .in_mulb(in_mulb[USED_W-1:0]),
    .s1_valid(s1_valid), .s1_hi(s1_hi), .s1_acc(s1_acc), .s1_a(s1_a), .s1_b(s1_b)
  );

  pmac_mul_stage #(.LANES(LANES)) u_mul (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_hi(s1_hi),
    .s1_acc(s1_acc), .s1_a(s1_a), .s1_b(s1_b),
    .s2_valid(s2_valid), .s2_hi(s2_hi), .s2_acc(s2_acc), .s2_prod(s2_prod)
  );

  pmac_sum_stage #(.LANES(LANES)) u_sum (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_hi(s2_hi),
    .s2_acc(s2_acc), .s2_prod(s2_prod),
    .s3_valid(s3_valid), .s3_sum(s3_sum)
  );

  assign out_valid = s3_valid;
  assign out_sum[USED_W-1:0] = s3_sum;

  if (LANES < PORT_LANES) begin : g_pad
    logic unused_upper_in;
    assign unused_upper_in = ^{in_acc[VEC_W-1:USED_W], in_mula[VEC_W-1:USED_W],
                               in_mulb[VEC_W-1:USED_W]};
    assign out_sum[VEC_W-1:USED_W] = '0;
  end
endmodule

// File: rtl/pmac52_checks.sv
module pmac52_checks (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_hi_sel,
  input logic         s1_valid,
  input logic         s1_hi,
  input logic         s2_valid,
  input logic         s2_hi,
  input logic         out_valid,
  input logic [103:0] mon_prod0,
  input logic [63:0]  mon_acc0,
  input logic [63:0]  mon_sum0
);
  // R6: each stage hands its valid to the next on every edge
  a_r6_capture_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  a_r6_mul_valid: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> s2_valid);
  a_r6_sum_valid: assert property (@(posedge clk) disable iff (rst)
    s2_valid |=> out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !s2_valid |=> !out_valid);

  // R8: reset empties the pipeline at the next edge
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !s1_valid && !s2_valid));

  // R9: the select bit travels with its operation
  a_r9_mode_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> (s1_hi == $past(in_hi_sel)));
  a_r9_mode_stage2: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (s2_hi == $past(s1_hi)));

  // R2: a zero product leaves the accumulator unchanged
  a_r2_zero_product: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && mon_prod0 == '0) |=> (mon_sum0 == $past(mon_acc0)));
endmodule

bind pmac52_unit pmac52_checks u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi_sel(in_hi_sel),
  .s1_valid(s1_valid), .s1_hi(s1_hi), .s2_valid(s2_valid), .s2_hi(s2_hi),
  .out_valid(out_valid), .mon_prod0(mon_prod0), .mon_acc0(mon_acc0),
  .mon_sum0(mon_sum0)
);

// File: tb/pmac52_unit_test.sv
`timescale 1ns/1ps
module pmac52_unit_test;
  localparam int TB_LANES = 2;
  localparam int PL       = 4;
  localparam int VW       = PL * 64;
  localparam logic [63:0] ONES52 = 64'h000F_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic        hi;
    logic [63:0] acc;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } row_t;

  localparam int NROW = 8;
  localparam row_t ROWS [NROW] = '{
    '{1'b1, 64'h0, ONES52, ONES52, 64'h000F_FFFF_FFFF_FFFE},
    '{1'b0, 64'h0, ONES52, ONES52, 64'h1},
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h5, 64'h4},
    '{1'b1, 64'h1234, 64'hFFF0_0000_0000_0003, 64'hABC0_0000_0000_0004, 64'h1234},
    '{1'b0, 64'h1234, 64'hFFF0_0000_0000_0003, 64'hABC0_0000_0000_0004, 64'h1240},
    '{1'b1, 64'h7, 64'h0008_0000_0000_0000, 64'h4, 64'h9},
    '{1'b0, 64'hDEAD, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD},
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, ONES52, ONES52, 64'h000F_FFFF_FFFF_FFFD}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_hi_sel = 1'b0;
  logic [VW-1:0] in_acc = '0, in_mula = '0, in_mulb = '0;
  logic out_valid;
  logic [VW-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pmac52_unit #(.LANES(TB_LANES), .PORT_LANES(PL)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi_sel(in_hi_sel),
    .in_acc(in_acc), .in_mula(in_mula), .in_mulb(in_mulb),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // Reference: shift/mask form of the lane rule.
  function automatic logic [63:0] lane_ref(logic hi, logic [63:0] acc,
                                           logic [63:0] a, logic [63:0] b);
    logic [127:0] p;
    p = (128'(a) & 128'(ONES52)) * (128'(b) & 128'(ONES52));
    if (hi) return acc + 64'(p >> 52);
    return acc + 64'(p & 128'(ONES52));
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard on the falling edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected out_valid", VW'(1), VW'(0));
      end else begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_sum === e, t, out_sum, e);
      end
    end
  end

  // Drive one operation for one cycle; lanes beyond TB_LANES get junk.
  task automatic send(input logic hi, input logic [VW-1:0] acc,
                      input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] exp, input string tag);
    in_valid  = 1'b1;
    in_hi_sel = hi;
    in_acc    = acc;
    in_mula   = a;
    in_mulb   = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] va, vb, vc, ve;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8 out_valid in reset", VW'(out_valid), VW'(0));
    rst = 1'b0;
    @(negedge clk);

    // Table walk, back to back (R6 throughput), lane 1 takes a rotated row.
    for (int i = 0; i < NROW; i++) begin
      int j;
      string t;
      j = (i + 3) % NROW;
      va = {64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_1234_5678, ROWS[j].acc, ROWS[i].acc};
      vb = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, ROWS[j].a, ROWS[i].a};
      vc = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210, ROWS[j].b, ROWS[i].b};
      ve = {128'h0, lane_ref(ROWS[i].hi, ROWS[j].acc, ROWS[j].a, ROWS[j].b), ROWS[i].exp};
      if (i == 2 || i == 7)      t = "R5 wraparound";
      else if (i == 3 || i == 4) t = "R1 junk high field bits";
      else if (i == 6)           t = "R2 zero multiplicand";
      else if (ROWS[i].hi)       t = "R3 upper half";
      else                       t = "R4 lower half";
      send(ROWS[i].hi, va, vb, vc, ve, t);
    end
    idle(5);

    // R9: alternating modes on identical operands, back to back
    for (int k = 0; k < 4; k++) begin
      logic h;
      h = k[0];
      va = {128'h0, 64'h10, 64'h20};
      vb = {128'h0, 64'h000F_0000_0000_0001, ONES52};
      vc = {128'h0, 64'h0000_1000_0000_0003, 64'h3};
      ve = {128'h0, lane_ref(h, 64'h10, 64'h000F_0000_0000_0001, 64'h0000_1000_0000_0003),
                    lane_ref(h, 64'h20, ONES52, 64'h3)};
      send(h, va, vb, vc, ve, "R9 mode per operation");
    end
    idle(5);

    // R7: lane independence, one lane all ones, other zero, upper junk
    va = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 64'hAAAA};
    vb = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, ONES52, 64'h0};
    vc = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, ONES52, 64'h0};
    ve = {128'h0, 64'h5 + 64'h000F_FFFF_FFFF_FFFE, 64'hAAAA};
    send(1'b1, va, vb, vc, ve, "R7 lane isolation and zero upper lanes");
    idle(5);

    // R6: exact latency of three edges
    va = {192'h0, 64'h3}; vb = {192'h0, 64'h2}; vc = {192'h0, 64'h2};
    send(1'b0, va, vb, vc, {192'h0, 64'h7}, "R6 latency data");
    in_valid = 1'b0;
    check(out_valid === 1'b0, "R6 not yet after one edge", VW'(out_valid), VW'(0));
    @(negedge clk);
    check(out_valid === 1'b0, "R6 not yet after two edges", VW'(out_valid), VW'(0));
    @(negedge clk);
    check(out_valid === 1'b1, "R6 valid after three edges", VW'(out_valid), VW'(1));
    @(negedge clk);
    check(out_valid === 1'b0, "R6 single-cycle valid", VW'(out_valid), VW'(0));
    idle(3);

    // R8: reset flushes an operation in flight
    in_valid = 1'b1;
    in_hi_sel = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(out_valid === 1'b0, "R8 flushed op stays invisible", VW'(out_valid), VW'(0));
      @(negedge clk);
    end

    check(exp_q.size() == 0, "R6 all results delivered", VW'(exp_q.size()), VW'(0));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule